// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block sequences one I2C master transaction at a time on behalf of software. Software writes registers on a simple word-wide bus. The sequencer then issues byte-level commands to a separate bus engine: START, STOP, write a byte, or read a byte and answer with ACK or NACK. The engine reports `eng_done` for each command. For writes it also returns the slave's acknowledge on `eng_ack`, and for reads it returns the received byte on `eng_rdata`. Pin timing, clock stretching and arbitration belong to the engine and are not handled here.

Data passes through a 32-byte transmit buffer and a 32-byte receive buffer. Each buffer is seen on the register bus as eight little-endian words. A transfer begins with a START. Software then launches the payload by writing a byte count. In plain transmit, the address byte is the first buffer byte. In register-transmit mode, the block sends the slave address and up to three register bytes by itself. It then turns the bus around with a fresh START and the read address, and receives. Receiving runs in chunks of up to 32 bytes. A STOP is sent only when software asks for it. Writing zero to the control register abandons the current state without a STOP, so that a new START can follow.

Top module: `i2c_xfer_seq`

## Requirements
- R1: Register byte offsets are: control 0x00, clock divider 0x04, slave address 0x08, register address 0x0C, transmit count 0x10, receive count 0x14, interrupt enable 0x18, interrupt pending 0x1C, finished count 0x20. The transmit buffer words are at 0x100..0x11C and the receive buffer words at 0x200..0x21C. After reset every register reads zero, `irq` is low and no command is issued. The divider register holds and returns whatever was written.
- R2: The control fields are: bit0 enable, bits 2:1 mode, bit3 start, bit4 stop, bit5 NACK on the last read byte, bit6 abort on NACK. Command codes on `cmd_op` are 0 START, 1 STOP, 2 write, 3 read with ACK, 4 read with NACK. When the start bit rises with enable set and the block is idle, exactly one START command is issued. When it is done, pending bit4 is set and the finished count reads 0.
- R3: In mode 0, a write to the transmit count while the bus is held sends that many buffer bytes, counts above 32 being taken as 32. Byte k is taken from word k/4, bits [8(k%4)+7:8(k%4)]. Each completed byte sets pending bit0 and adds one to the finished count. Pending bit2 is set after the last byte.
- R4: In mode 2 or 3, or in mode 1 once its address phase is over, a write to the receive count reads that many bytes (at most 32) without any address phase. Received byte k is stored in receive word k/4, bits [8(k%4)+7:8(k%4)]. Each byte sets pending bit1. Pending bit3 is set at the end. The finished count restarts from 0 for each chunk.
- R5: The last read of a chunk uses code 4 when control bit5 is set, and code 3 otherwise. Every other read uses code 3.
- R6: In mode 1, the first receive-count write starts by sending slave-address byte 0 if bit24 of that register is set. It then sends register-address bytes 0, 1 and 2 (bits 7:0, 15:8, 23:16) for each of bits 24, 25 and 26 that is set. If any register byte went out, a START and then slave-address byte 0 with bit0 forced to 1 follow. Reception comes after that.
- R7: In mode 1 with no register byte valid, reception follows the address byte directly, with no second START.
- R8: A write answered with NACK sets pending bit6. With control bit6 set, no further command is issued until a stop request. With bit6 clear, the transfer goes on.
- R9: Setting control bit4 while the bus is held, or after an abort, issues one STOP command. Its completion sets pending bit5.
- R10: Writing 1 to a pending bit clears it. A clear that lands in the same cycle as a new event for that bit loses to the event. `irq` is high exactly when some pending bit has its enable bit set.
- R11: Writing zero to the control register returns the block to idle without a STOP. A later rising start bit issues a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cmd_valid | output | 1 | One-cycle command strobe to the bus engine |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Byte to write (zero for other commands) |
| eng_done | input | 1 | Engine finished the outstanding command |
| eng_ack | input | 1 | Slave acknowledged the written byte (1 = ACK) |
| eng_rdata | input | 8 | Byte read by the engine |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the engine never raises `eng_done` unless a command is outstanding, and raises it only once per command. They also assume software rewrites the control register only while the bus is held, halted or idle. The bench's engine model answers each command once, two cycles after the strobe. Its register accesses wait until every expected command has gone out, so these conditions always hold. The command stream is checked against an expected queue built from the requirements, one command at a time as each is issued.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int BUF_WORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [9:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_valid,
  output logic [2:0]  cmd_op,
  output logic [7:0]  cmd_byte,
  input  logic        eng_done,
  input  logic        eng_ack,
  input  logic [7:0]  eng_rdata,
  output logic        irq
);
  localparam int MAXB = BUF_WORDS * 4;
  localparam int CW   = $clog2(MAXB + 1);
  localparam int WI   = $clog2(BUF_WORDS);
  localparam logic [2:0] OP_START = 3'd0, OP_STOP = 3'd1, OP_WR = 3'd2, OP_RACK = 3'd3, OP_RNACK = 3'd4;
  localparam logic [3:0] S_IDLE = 4'd0, S_START = 4'd1, S_HOLD = 4'd2, S_TX = 4'd3, S_RA = 4'd4,
                         S_RS = 4'd5, S_RA2 = 4'd6, S_RX = 4'd7, S_HALT = 4'd8, S_STOP = 4'd9;

  logic [6:0]    ctl, ien, ipd;
  logic [31:0]   clkdiv, saddr, raddr;
  logic [CW-1:0] txcnt, rxcnt, fcnt, idx, cnt_in;
  logic [31:0]   txbuf [BUF_WORDS];
  logic [31:0]   rxbuf [BUF_WORDS];
  logic [3:0]    st;
  logic          pend, start_q, regsent, addr_done, slot_v;
  logic [7:0]    slot_b;

  wire wr_ctl  = reg_we && reg_addr == 10'h000;
  wire wr_tx   = reg_we && reg_addr == 10'h010;
  wire wr_rx   = reg_we && reg_addr == 10'h014;
  wire ctl_rst = wr_ctl && reg_wdata[6:0] == 7'd0;
  wire [1:0] mode = ctl[2:1];
  wire last_rx = (idx + 1'b1) == rxcnt;
  wire nack_halt = !eng_ack && ctl[6];
  assign cnt_in = (reg_wdata > 32'(MAXB)) ? CW'(MAXB) : reg_wdata[CW-1:0];
  assign irq = |(ipd & ien);

  always_comb begin
    case (idx[1:0])
      2'd0: begin slot_v = saddr[24]; slot_b = saddr[7:0];   end
      2'd1: begin slot_v = raddr[24]; slot_b = raddr[7:0];   end
      2'd2: begin slot_v = raddr[25]; slot_b = raddr[15:8];  end
      default: begin slot_v = raddr[26]; slot_b = raddr[23:16]; end
    endcase
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_WR;
    cmd_byte  = 8'h00;
    if (!pend) begin
      case (st)
        S_START, S_RS: begin cmd_valid = 1'b1; cmd_op = OP_START; end
        S_STOP:        begin cmd_valid = 1'b1; cmd_op = OP_STOP;  end
        S_TX: if (idx != txcnt) begin
          cmd_valid = 1'b1;
          cmd_byte  = txbuf[idx[2 +: WI]][8*idx[1:0] +: 8];
        end
        S_RA: if (!idx[2] && slot_v) begin cmd_valid = 1'b1; cmd_byte = slot_b; end
        S_RA2: begin cmd_valid = 1'b1; cmd_byte = saddr[7:0] | 8'h01; end
        S_RX: if (idx != rxcnt) begin
          cmd_valid = 1'b1;
          cmd_op    = (last_rx && ctl[5]) ? OP_RNACK : OP_RACK;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    case (reg_addr[9:8])
      2'd0: case (reg_addr[7:0])
        8'h00: reg_rdata = {25'h0, ctl};
        8'h04: reg_rdata = clkdiv;
        8'h08: reg_rdata = saddr;
        8'h0C: reg_rdata = raddr;
        8'h10: reg_rdata = 32'(txcnt);
        8'h14: reg_rdata = 32'(rxcnt);
        8'h18: reg_rdata = {25'h0, ien};
        8'h1C: reg_rdata = {25'h0, ipd};
        8'h20: reg_rdata = 32'(fcnt);
        default: ;
      endcase
      2'd1: reg_rdata = txbuf[reg_addr[2 +: WI]];
      2'd2: reg_rdata = rxbuf[reg_addr[2 +: WI]];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; ien <= '0; ipd <= '0; clkdiv <= '0; saddr <= '0; raddr <= '0;
      txcnt <= '0; rxcnt <= '0; fcnt <= '0; idx <= '0; st <= S_IDLE;
      pend <= 1'b0; start_q <= 1'b0; regsent <= 1'b0; addr_done <= 1'b0;
      for (int i = 0; i < BUF_WORDS; i++) begin txbuf[i] <= '0; rxbuf[i] <= '0; end
    end else begin
      start_q <= ctl[3];
      if (cmd_valid) pend <= 1'b1;
      else if (eng_done) pend <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          10'h000: ctl    <= reg_wdata[6:0];
          10'h004: clkdiv <= reg_wdata;
          10'h008: saddr  <= reg_wdata;
          10'h00C: raddr  <= reg_wdata;
          10'h010: txcnt  <= cnt_in;
          10'h014: rxcnt  <= cnt_in;
          10'h018: ien    <= reg_wdata[6:0];
          10'h01C: ipd    <= ipd & ~reg_wdata[6:0];
          default: if (reg_addr[9:8] == 2'd1) txbuf[reg_addr[2 +: WI]] <= reg_wdata;
        endcase
      end
      if (ctl_rst) begin
        st <= S_IDLE; pend <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (ctl[3] && !start_q && ctl[0]) st <= S_START;
          S_START, S_RS: if (pend && eng_done) begin
            ipd[4] <= 1'b1;
            if (st == S_START) begin
              fcnt <= '0; addr_done <= 1'b0; regsent <= 1'b0; st <= S_HOLD;
            end else st <= S_RA2;
          end
          S_HOLD: begin
            if (ctl[4]) st <= S_STOP;
            else if (wr_tx && mode == 2'd0) begin
              st <= S_TX; idx <= '0; fcnt <= '0;
            end else if (wr_rx) begin
              idx <= '0; fcnt <= '0;
              st  <= (mode == 2'd1 && !addr_done) ? S_RA : S_RX;
            end
          end
          S_TX: if (pend) begin
            if (eng_done) begin
              ipd[0] <= 1'b1; fcnt <= fcnt + 1'b1; idx <= idx + 1'b1;
              if (!eng_ack) ipd[6] <= 1'b1;
              if (nack_halt) st <= S_HALT;
            end
          end else if (idx == txcnt) begin
            ipd[2] <= 1'b1; st <= S_HOLD;
          end
          S_RA: if (pend) begin
            if (eng_done) begin
              ipd[0] <= 1'b1; idx <= idx + 1'b1;
              if (idx != '0) regsent <= 1'b1;
              if (!eng_ack) ipd[6] <= 1'b1;
              if (nack_halt) st <= S_HALT;
            end
          end else if (idx[2]) begin
            addr_done <= 1'b1; idx <= '0;
            st <= regsent ? S_RS : S_RX;
          end else if (!slot_v) idx <= idx + 1'b1;
          S_RA2: if (pend && eng_done) begin
            ipd[0] <= 1'b1; st <= S_RX;
            if (!eng_ack) ipd[6] <= 1'b1;
            if (nack_halt) st <= S_HALT;
          end
          S_RX: if (pend) begin
            if (eng_done) begin
              rxbuf[idx[2 +: WI]][8*idx[1:0] +: 8] <= eng_rdata;
              ipd[1] <= 1'b1; fcnt <= fcnt + 1'b1; idx <= idx + 1'b1;
            end
          end else if (idx == rxcnt) begin
            ipd[3] <= 1'b1; st <= S_HOLD;
          end
          S_HALT: if (ctl[4]) st <= S_STOP;
          S_STOP: if (pend && eng_done) begin ipd[5] <= 1'b1; st <= S_IDLE; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module i2c_xfer_seq_chk #(
  parameter int CW = 6,
  parameter int MAXB = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          eng_done,
  input logic          eng_ack,
  input logic          ctl_en,
  input logic          ctl_abort,
  input logic          in_tx,
  input logic          in_rx,
  input logic          in_stop,
  input logic [6:0]    ipd,
  input logic [CW-1:0] fcnt
);
  a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0) |-> ctl_en);
  a_r2_cmd_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r8_abort_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tx && eng_done && !eng_ack && ctl_abort) |=> !cmd_valid);
  a_r9_stop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && eng_done) |=> ipd[5]);
  a_r4_rx_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rx && eng_done) |=> ipd[1]);
  a_r3_fcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CW'(MAXB));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk #(.CW(CW), .MAXB(MAXB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .eng_done(eng_done), .eng_ack(eng_ack), .ctl_en(ctl[0]), .ctl_abort(ctl[6]),
  .in_tx(st == S_TX), .in_rx(st == S_RX), .in_stop(st == S_STOP),
  .ipd(ipd), .fcnt(fcnt));

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic eng_done = 1'b0, eng_ack = 1'b1;
  logic [7:0] eng_rdata = '0;
  logic irq;

  int n_chk = 0, n_bad = 0, eng_cnt = 0;
  bit finished = 0;
  string cur_req = "R1";
  logic [10:0] exp_q[$];
  bit ack_q[$];
  logic [2:0] eng_op;
  logic [7:0] rd_val = 8'h30;

  always #10 clk = ~clk;

  i2c_xfer_seq dut (.*);

  function automatic logic [10:0] cm(input logic [2:0] op, input logic [7:0] b);
    return {op, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // engine model and per-command comparison, all at the falling edge
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        eng_done = 1'b1;
        eng_ack = 1'b1;
        if (eng_op == 3'd2 && ack_q.size() > 0) eng_ack = ack_q.pop_front();
        if (eng_op == 3'd3 || eng_op == 3'd4) begin eng_rdata = rd_val; rd_val++; end
      end
    end
    if (cmd_valid && rst_n) begin
      eng_op = cmd_op;
      eng_cnt = 2;
      if (exp_q.size() == 0) check({cur_req, " unexpected command"}, {21'h0, cmd_op, cmd_byte}, 32'hFFFF_FFFF);
      else check({cur_req, " command"}, {21'h0, cmd_op, cmd_byte}, {21'h0, exp_q.pop_front()});
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    check({req, " all commands issued"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] b0;
    wait_c(3); #1 rst_n = 1'b1;
    // R1 reset values and divider storage
    cur_req = "R1";
    rd(10'h000, v); check("R1 ctl", v, 0);
    rd(10'h01C, v); check("R1 ipd", v, 0);
    rd(10'h020, v); check("R1 fcnt", v, 0);
    check("R1 irq", {31'h0, irq}, 0);
    check("R1 cmd_valid", {31'h0, cmd_valid}, 0);
    wr(10'h004, 32'h0003_0005); rd(10'h004, v); check("R1 clkdiv", v, 32'h0003_0005);

    // R2 start, R3 plain transmit
    wr(10'h100, 32'h3322_11A0); wr(10'h104, 32'h0000_0044);
    cur_req = "R2"; exp_q.push_back(cm(0, 0));
    wr(10'h000, 32'h49); wait_c(10);
    rd(10'h01C, v); check("R2 start pending", v, 32'h10);
    rd(10'h020, v); check("R2 fcnt", v, 0);
    drained("R2");
    wr(10'h01C, 32'h7F); rd(10'h01C, v); check("R10 w1c", v, 0);
    cur_req = "R3";
    exp_q.push_back(cm(2, 8'hA0)); exp_q.push_back(cm(2, 8'h11)); exp_q.push_back(cm(2, 8'h22));
    exp_q.push_back(cm(2, 8'h33)); exp_q.push_back(cm(2, 8'h44));
    wr(10'h010, 5); wait_c(40);
    rd(10'h01C, v); check("R3 pending", v, 32'h05);
    rd(10'h020, v); check("R3 fcnt", v, 5);
    drained("R3");
    cur_req = "R9"; exp_q.push_back(cm(1, 0));
    wr(10'h000, 32'h59); wait_c(10);
    rd(10'h01C, v); check("R9 stop pending", v, 32'h25);
    drained("R9");

    // R10 irq gating
    wr(10'h018, 32'h20); wait_c(1); check("R10 irq on", {31'h0, irq}, 1);
    wr(10'h01C, 32'h20); wait_c(1); check("R10 irq off", {31'h0, irq}, 0);
    rd(10'h01C, v); check("R10 other bits kept", v, 32'h05);
    wr(10'h018, 32'h04); wait_c(1); check("R10 irq bit2", {31'h0, irq}, 1);
    wr(10'h018, 0); wr(10'h01C, 32'h7F); wr(10'h000, 0);

    // R8 abort on NACK
    cur_req = "R8";
    wr(10'h100, 32'h5655_54A0);
    exp_q.push_back(cm(0, 0));
    wr(10'h000, 32'h49); wait_c(10); wr(10'h01C, 32'h7F);
    ack_q.push_back(1); ack_q.push_back(0);
    exp_q.push_back(cm(2, 8'hA0)); exp_q.push_back(cm(2, 8'h54));
    wr(10'h010, 4); wait_c(40);
    rd(10'h01C, v); check("R8 abort pending", v, 32'h41);
    rd(10'h020, v); check("R8 abort fcnt", v, 2);
    drained("R8");
    cur_req = "R9"; exp_q.push_back(cm(1, 0));
    wr(10'h000, 32'h59); wait_c(10);
    rd(10'h01C, v); check("R9 stop after abort", v, 32'h61);
    drained("R9");
    wr(10'h000, 0); wr(10'h01C, 32'h7F);

    // R8 NACK without abort continues
    cur_req = "R8"; exp_q.push_back(cm(0, 0));
    wr(10'h000, 32'h09); wait_c(10); wr(10'h01C, 32'h7F);
    ack_q.push_back(0);
    exp_q.push_back(cm(2, 8'hA0)); exp_q.push_back(cm(2, 8'h54));
    exp_q.push_back(cm(2, 8'h55)); exp_q.push_back(cm(2, 8'h56));
    wr(10'h010, 4); wait_c(40);
    rd(10'h01C, v); check("R8 continue pending", v, 32'h45);
    rd(10'h020, v); check("R8 continue fcnt", v, 4);
    drained("R8");
    cur_req = "R9"; exp_q.push_back(cm(1, 0));
    wr(10'h000, 32'h19); wait_c(10); drained("R9");
    wr(10'h000, 0); wr(10'h01C, 32'h7F);

    // R11 control zero without STOP, then a fresh START
    cur_req = "R11"; exp_q.push_back(cm(0, 0));
    wr(10'h000, 32'h09); wait_c(10);
    wr(10'h000, 0); wait_c(10); drained("R11 no stop");
    wr(10'h01C, 32'h7F);
    exp_q.push_back(cm(0, 0));
    wr(10'h000, 32'h09); wait_c(10);
    rd(10'h01C, v); check("R11 new start", v, 32'h10);
    drained("R11");
    wr(10'h000, 0); wr(10'h01C, 32'h7F);

    // R6 register transmit with two register bytes, R5 last byte NACK
    cur_req = "R6";
    wr(10'h008, 32'h0100_00A0); wr(10'h00C, 32'h0300_3412);
    exp_q.push_back(cm(0, 0));
    wr(10'h000, 32'h2B); wait_c(10); wr(10'h01C, 32'h7F);
    exp_q.push_back(cm(2, 8'hA0)); exp_q.push_back(cm(2, 8'h12)); exp_q.push_back(cm(2, 8'h34));
    exp_q.push_back(cm(0, 0)); exp_q.push_back(cm(2, 8'hA1));
    exp_q.push_back(cm(3, 0)); exp_q.push_back(cm(3, 0)); exp_q.push_back(cm(4, 0));
    b0 = rd_val;
    wr(10'h014, 3); wait_c(60);
    rd(10'h200, v); check("R4 rx word", v, {8'h00, b0 + 8'd2, b0 + 8'd1, b0});
    rd(10'h01C, v); check("R6 pending", v, 32'h1B);
    rd(10'h020, v); check("R4 fcnt", v, 3);
    drained("R6/R5");

    // R4 second chunk in plain receive, R5 last byte ACK
    cur_req = "R4";
    wr(10'h000, 32'h0D); wr(10'h01C, 32'h7F);
    exp_q.push_back(cm(3, 0)); exp_q.push_back(cm(3, 0));
    v = {8'h00, b0 + 8'd2, 16'h0};
    b0 = rd_val;
    v[15:0] = {b0 + 8'd1, b0};
    wr(10'h014, 2); wait_c(30);
    begin
      logic [31:0] got;
      rd(10'h200, got); check("R4 chunk2 word", got, v);
    end
    rd(10'h01C, v); check("R4 chunk2 pending", v, 32'h0A);
    rd(10'h020, v); check("R4 chunk2 fcnt", v, 2);
    drained("R4/R5");
    cur_req = "R9"; exp_q.push_back(cm(1, 0));
    wr(10'h000, 32'h1D); wait_c(10); drained("R9");
    wr(10'h000, 0); wr(10'h01C, 32'h7F);

    // R7 register transmit without register bytes
    cur_req = "R7";
    wr(10'h008, 32'h0100_00A1); wr(10'h00C, 0);
    exp_q.push_back(cm(0, 0));
    wr(10'h000, 32'h2B); wait_c(10); wr(10'h01C, 32'h7F);
    exp_q.push_back(cm(2, 8'hA1)); exp_q.push_back(cm(4, 0));
    wr(10'h014, 1); wait_c(30);
    rd(10'h01C, v); check("R7 pending", v, 32'h0B);
    drained("R7");
    cur_req = "R9"; exp_q.push_back(cm(1, 0));
    wr(10'h000, 32'h3B); wait_c(10); drained("R9");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule